// File: doc/BRIEF.md
# Multi-Stage Error-Feedback Fraction Modulator

This block turns a fixed-point fractional word into a stream of small signed integer corrections, one per feedback-divider cycle. Added to the swallow count of a dual-modulus divider, the corrections make the long-run average divide ratio grow by `K/2^18`. The quantisation error is pushed towards high frequencies, so the loop filter removes most of it.

The block chains first-order accumulators. Each stage accumulates the residue left by the stage before it. Their overflow carries are merged by a differencing network that cancels the error of the earlier stages. A select input picks either two stages (second-order shaping) or three stages (third-order shaping), and it may change while the block runs. An optional dither bit sits one position below the fractional word. When enabled, it alternates on every clock. This breaks up periodic patterns in the carries, at the price of a small fixed upward shift of the mean frequency.

The block is clocked by the divided feedback signal. Its output is registered, so each correction appears one clock after the inputs it was computed from.

Top module: `mash_modulator`

## Requirements
- R1: A synchronous active-low reset clears every accumulator, every carry delay register and the dither bit. While reset is held low at a clock edge, the output after that edge is 0.
- R2: Each stage is a `(FRAC_W+1)`-bit accumulator, 19 bits by default. The first stage adds `{frac_k, d}` on every clock, with `frac_k` in bits 18..1 and the dither bit `d` in bit 0. Stage n+1 adds the new residue of stage n. A stage's carry is 1 when its sum reaches 2^19, and the residue is the sum modulo 2^19.
- R3: With `two_stage` high, the output registered at edge n is `c1[n] + c2[n] - c2[n-1]`, where cX[n] is the carry of stage X at edge n. It is a 4-bit two's-complement value that always lies in the range -1 to +2.
- R4: With `two_stage` low, the output registered at edge n is `c1[n] + c2[n] - c2[n-1] + c3[n] - 2*c3[n-1] + c3[n-2]`. It always lies in the range -3 to +4.
- R5: `two_stage` only chooses which terms form the output. All three stages and all delay registers keep running in both settings, so changing the select at run time needs no reset and causes no step in the accumulator state.
- R6: While `dither_en` is high the dither bit inverts on every clock. Its value is 0 on the first enabled clock after being disabled or after reset. While `dither_en` is low the dither bit is 0.
- R7: With `frac_k` = 0 and the dither disabled from reset onward, every output is 0.
- R8: With the two-stage setting and the dither disabled, the first 2^18 outputs after reset sum to exactly `frac_k`. Equivalently, for `frac_k` a multiple of 2^12, the first 64 outputs sum to `frac_k/2^12`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Feedback-divider clock; one correction per rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| frac_k | input | 18 | Fractional word, ratio `frac_k/2^18` |
| two_stage | input | 1 | High: two-stage output; low: three-stage output |
| dither_en | input | 1 | Enables the alternating bit below `frac_k` |
| offset | output | 4 | Signed swallow-count correction, two's complement |

## Verification
The hardest situations to reach from the ports are the extreme output values (+4 and -3 in the three-stage setting). These need a precise pattern of third-stage carries over three successive clocks, which a smooth input rarely gives. The stimulus therefore combines long runs at fractional words close to full scale and close to zero with runs where `frac_k` takes a new pseudo-random value every clock, and it switches the stage count in the middle of runs. A cycle-exact integer model in the bench predicts every output. A 64-cycle window with a coarse fractional word confirms the exact long-run sum.

// File: rtl/mash_pkg.sv
// Package: shared widths for the fraction modulator.
// Assumes at most three cascaded stages; the output width covers -3..+4.
package mash_pkg;
    localparam int unsigned MAX_STAGES = 3;
    localparam int unsigned OFS_W      = 4;
    typedef logic signed [OFS_W-1:0] mash_ofs_t;
endpackage

// File: rtl/mash_acc_stage.sv
// One first-order error-feedback stage: adds its input to a stored residue,
// reports the overflow carry and presents the new residue combinationally so
// the next stage can consume it in the same clock.
// Assumes add_in is always below 2^ACC_W (no wider operands).
module mash_acc_stage #(
    parameter int unsigned ACC_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] add_in,
    output logic [ACC_W-1:0] res_next,
    output logic             carry
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum_w;

    // Purpose: form the wide sum and split it into carry and residue.
    always_comb begin
        sum_w    = {1'b0, acc_q} + {1'b0, add_in};
        carry    = sum_w[ACC_W];
        res_next = sum_w[ACC_W-1:0];
    end

    // Purpose: store the residue for the next clock.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= res_next;
    end

    // R2: an overflow always leaves a residue below the added value.
    assert_carry_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (res_next < add_in));
    // R2: no overflow means the residue did not shrink below the addend.
    assert_no_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !carry |-> (res_next >= add_in));
endmodule

// File: rtl/mash_lsb_dither.sv
// Dither source: a single bit that inverts on each enabled clock and is held
// at 0 while disabled. Assumes the enable is synchronous to clk.
module mash_lsb_dither (
    input  logic clk,
    input  logic rst_n,
    input  logic dither_en,
    output logic dith_q
);
    // Purpose: alternate while enabled, park at 0 otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)         dith_q <= 1'b0;
        else if (dither_en) dith_q <= ~dith_q;
        else                dith_q <= 1'b0;
    end

    // R6: an enabled clock always inverts the bit.
    assert_dither_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dither_en |=> (dith_q != $past(dith_q)));
    // R6: a disabled clock leaves the bit at 0.
    assert_dither_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !dither_en |=> !dith_q);
endmodule

// File: rtl/mash_cancel.sv
// Noise-cancelling network: delays the later-stage carries, differences them
// and sums them with the first carry. The stage count selects which terms
// contribute. Result is registered. Assumes carries are single bits.
module mash_cancel
    import mash_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MAX_STAGES-1:0] carry,
    input  logic                  two_stage,
    output mash_ofs_t             ofs_q
);
    localparam int unsigned SW = OFS_W + 1;

    logic          c2_d, c3_d, c3_dd;
    logic [SW-1:0] part_two, part_three, pick;

    // Purpose: carry delay line, always running whatever the stage count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else begin
            c2_d  <= carry[1];
            c3_d  <= carry[2];
            c3_dd <= c3_d;
        end
    end

    // Purpose: build both candidate sums in modulo-2^SW arithmetic.
    always_comb begin
        part_two   = SW'(carry[0]) + SW'(carry[1]) - SW'(c2_d);
        part_three = part_two + SW'(carry[2]) - SW'({c3_d, 1'b0}) + SW'(c3_dd);
        pick       = two_stage ? part_two : part_three;
    end

    // Purpose: register the selected correction.
    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= '0;
        else        ofs_q <= mash_ofs_t'(pick[OFS_W-1:0]);
    end

    // R1: reset held at an edge gives a zero output after it.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (ofs_q == '0));
    // R3: two-stage corrections stay within -1..+2.
    assert_range_two_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(two_stage) |-> (ofs_q >= -4'sd1 && ofs_q <= 4'sd2));
    // R4: every correction stays within -3..+4.
    assert_range_three_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q >= -4'sd3 && ofs_q <= 4'sd4));
endmodule

// File: rtl/mash_modulator.sv
// Top of the fraction modulator: dither source, three cascaded accumulator
// stages and the cancelling network. One correction per feedback clock.
// Assumes frac_k and the selects are stable around the rising edge of clk.
module mash_modulator #(
    parameter int unsigned FRAC_W = 18
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [FRAC_W-1:0]                    frac_k,
    input  logic                                 two_stage,
    input  logic                                 dither_en,
    output logic signed [mash_pkg::OFS_W-1:0]    offset
);
    import mash_pkg::*;

    localparam int unsigned ACC_W = FRAC_W + 1;

    logic                  dith;
    logic [ACC_W-1:0]      stage_in  [MAX_STAGES];
    logic [ACC_W-1:0]      stage_res [MAX_STAGES];
    logic [MAX_STAGES-1:0] carry;
    mash_ofs_t             ofs;

    mash_lsb_dither u_dither (
        .clk      (clk),
        .rst_n    (rst_n),
        .dither_en(dither_en),
        .dith_q   (dith)
    );

    // Purpose: first stage takes the fractional word with the dither bit below it.
    always_comb stage_in[0] = {frac_k, dith};

    for (genvar s = 0; s < MAX_STAGES; s++) begin : g_stage
        if (s > 0) begin : g_link
            // Purpose: each later stage eats the fresh residue of the one before.
            always_comb stage_in[s] = stage_res[s-1];
        end
        mash_acc_stage #(.ACC_W(ACC_W)) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .add_in  (stage_in[s]),
            .res_next(stage_res[s]),
            .carry   (carry[s])
        );
    end

    mash_cancel u_cancel (
        .clk      (clk),
        .rst_n    (rst_n),
        .carry    (carry),
        .two_stage(two_stage),
        .ofs_q    (ofs)
    );

    assign offset = ofs;
endmodule

// File: tb/sim_mash_modulator.sv
module sim_mash_modulator;
    localparam int     FW   = 18;
    localparam longint MOD  = 64'd1 << (FW + 1);
    localparam longint MSK  = MOD - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [FW-1:0] frac_k = '0;
    logic          two_stage = 1'b1;
    logic          dither_en = 1'b0;
    logic signed [3:0] offset;

    always #2.5 clk = ~clk;   // 200 MHz

    mash_modulator u0 (
        .clk(clk), .rst_n(rst_n), .frac_k(frac_k),
        .two_stage(two_stage), .dither_en(dither_en), .offset(offset)
    );

    int    n_chk = 0, n_fail = 0;
    int    exp_q[$];
    string tag_q[$];
    int    win_sum = 0;
    bit    done = 1'b0;

    // independent integer model of the requirements
    longint m_a1, m_a2, m_a3;
    int     m_c2d, m_c3d, m_c3dd, m_d;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    // monitor: pops one expected item per edge and compares it
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, int'(offset), e);
            if (t == "R8") win_sum += int'(offset);
        end
    end

    // driver: sets inputs for the next edge and pushes its expected result
    task automatic step(input logic rst, input int k, input logic two,
                        input logic den, input string tag);
        int y, c1, c2, c3;
        longint s;
        @(negedge clk);
        rst_n = rst; frac_k = FW'(k); two_stage = two; dither_en = den;
        if (!rst) begin
            m_a1 = 0; m_a2 = 0; m_a3 = 0;
            m_c2d = 0; m_c3d = 0; m_c3dd = 0; m_d = 0;
            y = 0;
        end else begin
            s = m_a1 + ((longint'(k) << 1) | m_d);
            c1 = int'(s >> (FW + 1)); m_a1 = s & MSK;
            s = m_a2 + m_a1;
            c2 = int'(s >> (FW + 1)); m_a2 = s & MSK;
            s = m_a3 + m_a2;
            c3 = int'(s >> (FW + 1)); m_a3 = s & MSK;
            y = c1 + c2 - m_c2d;
            if (!two) y = y + c3 - 2 * m_c3d + m_c3dd;
            m_c3dd = m_c3d; m_c3d = c3; m_c2d = c2;
            m_d = den ? (m_d ^ 1) : 0;
        end
        exp_q.push_back(y);
        tag_q.push_back(tag);
    endtask

    task automatic drain();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        repeat (3) step(1'b0, 0, 1'b1, 1'b0, "R1");
        // R7: zero word, no dither
        repeat (40) step(1'b1, 0, 1'b1, 1'b0, "R7");
        // R3: two-stage run
        repeat (200) step(1'b1, 'h2A5B3, 1'b1, 1'b0, "R3");
        // R5: switch to three stages mid-run
        repeat (300) step(1'b1, 'h2A5B3, 1'b0, 1'b0, "R5");
        // R4: near full scale and near zero, three stages
        repeat (200) step(1'b1, 'h3FFFF, 1'b0, 1'b0, "R4");
        repeat (200) step(1'b1, 'h00001, 1'b0, 1'b0, "R4");
        // R5: back to two stages without reset
        repeat (100) step(1'b1, 'h1C001, 1'b1, 1'b0, "R5");
        // R6: dither enabled in both settings, then off again
        repeat (150) step(1'b1, 1, 1'b1, 1'b1, "R6");
        repeat (150) step(1'b1, 'h3FFFF, 1'b0, 1'b1, "R6");
        repeat (20)  step(1'b1, 0, 1'b0, 1'b0, "R6");
        // R2: new pseudo-random word every clock, mixed settings
        for (int i = 0; i < 600; i++)
            step(1'b1, int'($urandom_range(0, (1 << FW) - 1)), logic'(i[6]),
                 logic'(i[4]), "R2");
        // R1: reset in the middle of activity
        repeat (2) step(1'b0, 'h12345, 1'b0, 1'b1, "R1");
        repeat (50) step(1'b1, 'h12345, 1'b0, 1'b1, "R4");
        // R8: exact sum over 64 outputs for K = 5 * 2^12
        step(1'b0, 0, 1'b1, 1'b0, "R1");
        drain();
        win_sum = 0;
        repeat (64) step(1'b1, 5 * 4096, 1'b1, 1'b0, "R8");
        drain();
        check("R8", win_sum, 5);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(50000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule